// File: doc/BRIEF.md
# Indirect Classifier Table Access Controller

This block gives a host processor access to the internal tables of a packet classifier through a narrow register window. The classifier tables are a packet staging memory for each of three parsers, a shared parse-tree memory, a shared search-tree memory and a shared result memory. Each table entry is seventeen 32-bit words. To reach an entry, software first writes a selector register that names a memory type and an entry index. It then fills or reads seventeen staging registers and issues a one-hot command. It polls a status register until that command's bit appears.

A write command copies the staging words into the selected entry, one word per cycle. A read command copies the entry back into the staging registers. Search-tree add, delete and search commands are accepted and reported as complete without touching any table. A command that names an unmapped type, an index past the table depth, or an unknown code still completes, but it changes nothing and raises a sticky error flag. The block also holds a start-node pointer and a start-packet pointer for each parser.

Top module: `cle_indirect_ctrl`

## Requirements
- R1: Register offsets are: selector 0x04, command 0x08, status 0x0C, and staging word i at 0x10 + 4*i for i = 0..16. The selector, command and staging registers read back the last value written. Read data appears on csr_rdata with csr_rvalid high on the cycle after the edge that samples csr_re. Unmapped offsets read as zero.
- R2: Selector bits 31:28 give the memory type and bits 27:0 give the entry index. Types 0x0, 0x4 and 0x8 are the packet memories of parsers 0, 1 and 2, each a separate table. Type 0xC (parse tree), 0xD (search tree) and 0xE (result) are single tables shared by all parsers. Every other type is unmapped.
- R3: Command code 1 (write) stores all 17 staging words into the selected entry.
- R4: Command code 2 (read) loads all 17 words of the selected entry into the staging registers.
- R5: Accepting a command clears status bits 5:0. The status bit equal to the command code is set on the 18th rising edge after the accepting edge, so a read sampled on that edge still returns 0. At most one of bits 5:0 is set at any time.
- R6: Command codes 8, 16 and 32 complete with their own code in status bits 5:0. They change no table and set no error.
- R7: A write or read whose type is unmapped, or whose full 28-bit index is not below the table depth, completes with its code in status. It changes no table or staging word, and it sets status bit 31. Bit 31 stays set until software writes the status register with bit 31 = 1.
- R8: A command value other than 1, 2, 8, 16 or 32 completes with status bits 5:0 all zero and sets status bit 31.
- R9: While a command is in progress, writes to the command, selector and staging registers are ignored.
- R10: Parser p (0..2) has a start-node register at 0x100 + 0x200*p holding 14 bits and a start-packet register at 0x104 + 0x200*p holding 9 bits. Unused bits read zero, and each parser's registers are independent.
- R11: After reset, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe |
| csr_addr | input | CSR_AW | Byte offset of the register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| csr_rvalid | output | 1 | High for one cycle when csr_rdata holds read data |

## Verification
The embedded assertions check, on every cycle, that:
- at most one completion bit is set;
- a completion bit only rises after the sequencer signals the end of a command;
- the error flag only clears through its write-one-to-clear path;
- a table write strobe only occurs for an accepted, in-range write command;
- the staging registers hold still while a transfer is running, except where the sequencer loads them.

Only the bench scenarios can show the following:
- that the data words land in the right entry and the right table;
- that parser packet tables are kept apart;
- that an index with stray high bits does not alias onto a real entry;
- the exact cycle at which completion becomes visible.

// File: rtl/cle_ind_pkg.sv
package cle_ind_pkg;
  localparam int NWORDS   = 17;
  localparam int NPARSERS = 3;
  localparam int IDXW     = 28;
  localparam int NREGIONS = NPARSERS + 3;
  localparam int RGN_W    = $clog2(NREGIONS);

  localparam int RGN_TREE = NPARSERS;
  localparam int RGN_SRCH = NPARSERS + 1;
  localparam int RGN_RES  = NPARSERS + 2;

  localparam logic [3:0] TYPE_PKT  = 4'h0;
  localparam logic [3:0] TYPE_TREE = 4'hC;
  localparam logic [3:0] TYPE_SRCH = 4'hD;
  localparam logic [3:0] TYPE_RES  = 4'hE;

  localparam logic [31:0] CMD_WR   = 32'd1;
  localparam logic [31:0] CMD_RD   = 32'd2;
  localparam logic [31:0] CMD_ADD  = 32'd8;
  localparam logic [31:0] CMD_DEL  = 32'd16;
  localparam logic [31:0] CMD_SRCH = 32'd32;

  localparam int OFF_SEL   = 'h04;
  localparam int OFF_CMD   = 'h08;
  localparam int OFF_STAT  = 'h0C;
  localparam int OFF_STG   = 'h10;
  localparam int OFF_SNODE = 'h100;
  localparam int OFF_SPKT  = 'h104;
  localparam int OFF_BANK  = 'h200;
  localparam int SNODE_W   = 14;
  localparam int SPKT_W    = 9;

  function automatic logic known_cmd(input logic [31:0] c);
    return (c == CMD_WR) || (c == CMD_RD) || (c == CMD_ADD) ||
           (c == CMD_DEL) || (c == CMD_SRCH);
  endfunction

  function automatic int region_depth(input int r, input int pkt, input int tree,
                                      input int srch, input int res);
    if (r < NPARSERS) return pkt;
    if (r == RGN_TREE) return tree;
    if (r == RGN_SRCH) return srch;
    return res;
  endfunction
endpackage

// File: rtl/cle_region_map.sv
module cle_region_map import cle_ind_pkg::*; #(
  parameter int PKT_DEPTH  = 16,
  parameter int TREE_DEPTH = 32,
  parameter int SRCH_DEPTH = 16,
  parameter int RES_DEPTH  = 16
) (
  input  logic [3:0]       mem_type,
  input  logic [IDXW-1:0]  index,
  output logic [RGN_W-1:0] region,
  output logic             ok
);
  logic            mapped;
  logic [IDXW-1:0] depth;

  always_comb begin
    mapped = 1'b1;
    region = '0;
    depth  = IDXW'(PKT_DEPTH);
    unique case (mem_type)
      4'h0, 4'h4, 4'h8: region = RGN_W'(mem_type[3:2]);
      TYPE_TREE: begin region = RGN_W'(RGN_TREE); depth = IDXW'(TREE_DEPTH); end
      TYPE_SRCH: begin region = RGN_W'(RGN_SRCH); depth = IDXW'(SRCH_DEPTH); end
      TYPE_RES:  begin region = RGN_W'(RGN_RES);  depth = IDXW'(RES_DEPTH);  end
      default:   mapped = 1'b0;
    endcase
    ok = mapped && (index < depth);
  end
endmodule

// File: rtl/cle_word_ram.sv
module cle_word_ram #(
  parameter int WORDS = 272,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cle_xfer_seq.sv
module cle_xfer_seq #(
  parameter int NW = 17,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          do_wr,
  input  logic          do_rd,
  input  logic [AW-1:0] base,
  output logic          busy,
  output logic          done,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [$clog2(NW+1)-1:0] word_idx,
  output logic          stage_we,
  output logic [$clog2(NW+1)-1:0] stage_idx
);
  localparam int CW = $clog2(NW + 1);
  logic [CW-1:0] cnt;
  logic          wr_q, rd_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cnt <= '0; wr_q <= 1'b0; rd_q <= 1'b0; base_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; cnt <= '0; wr_q <= do_wr; rd_q <= do_rd; base_q <= base;
      end
    end else if (cnt == CW'(NW)) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done      = busy && (cnt == CW'(NW));
  assign word_idx  = (cnt < CW'(NW)) ? cnt : '0;
  assign mem_addr  = base_q + AW'(word_idx);
  assign mem_we    = busy && wr_q && (cnt < CW'(NW));
  assign stage_we  = busy && rd_q && (cnt != '0);
  assign stage_idx = cnt - 1'b1;
endmodule

// File: rtl/cle_indirect_ctrl.sv
module cle_indirect_ctrl import cle_ind_pkg::*; #(
  parameter int CSR_AW     = 12,
  parameter int PKT_DEPTH  = 16,
  parameter int TREE_DEPTH = 32,
  parameter int SRCH_DEPTH = 16,
  parameter int RES_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              csr_rvalid
);
  localparam int MAXD = (PKT_DEPTH > TREE_DEPTH ? PKT_DEPTH : TREE_DEPTH) >
                        (SRCH_DEPTH > RES_DEPTH ? SRCH_DEPTH : RES_DEPTH) ?
                        (PKT_DEPTH > TREE_DEPTH ? PKT_DEPTH : TREE_DEPTH) :
                        (SRCH_DEPTH > RES_DEPTH ? SRCH_DEPTH : RES_DEPTH);
  localparam int AW = $clog2(MAXD * NWORDS);
  localparam int CW = $clog2(NWORDS + 1);

  logic [31:0]                  sel_q, cmd_q;
  logic [5:0]                   done_q;
  logic                         err_q, bad_q, ok_q;
  logic [RGN_W-1:0]             region_q;
  logic [NWORDS-1:0][31:0]      staging;
  logic [NPARSERS-1:0][SNODE_W-1:0] snode;
  logic [NPARSERS-1:0][SPKT_W-1:0]  spkt;

  logic [RGN_W-1:0] map_rgn;
  logic             map_ok;
  cle_region_map #(.PKT_DEPTH(PKT_DEPTH), .TREE_DEPTH(TREE_DEPTH),
                   .SRCH_DEPTH(SRCH_DEPTH), .RES_DEPTH(RES_DEPTH)) u_map (
    .mem_type(sel_q[31:28]), .index(sel_q[IDXW-1:0]), .region(map_rgn), .ok(map_ok));

  logic            seq_busy, seq_done, seq_we, seq_swe;
  logic [AW-1:0]   seq_addr;
  logic [CW-1:0]   seq_word, seq_sidx;
  logic [IDXW-1:0] base_full;
  logic            cmd_acc, is_wr, is_rd;

  assign cmd_acc   = csr_we && (csr_addr == CSR_AW'(OFF_CMD)) && !seq_busy;
  assign is_wr     = csr_wdata == CMD_WR;
  assign is_rd     = csr_wdata == CMD_RD;
  assign base_full = sel_q[IDXW-1:0] * IDXW'(NWORDS);

  cle_xfer_seq #(.NW(NWORDS), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(cmd_acc),
    .do_wr(is_wr && map_ok), .do_rd(is_rd && map_ok), .base(AW'(base_full)),
    .busy(seq_busy), .done(seq_done), .mem_we(seq_we), .mem_addr(seq_addr),
    .word_idx(seq_word), .stage_we(seq_swe), .stage_idx(seq_sidx));

  logic [31:0] ram_rd [NREGIONS];
  for (genvar r = 0; r < NREGIONS; r++) begin : g_ram
    localparam int RWORDS = region_depth(r, PKT_DEPTH, TREE_DEPTH, SRCH_DEPTH, RES_DEPTH) * NWORDS;
    cle_word_ram #(.WORDS(RWORDS), .AW(AW)) u_ram (
      .clk(clk), .we(seq_we && (region_q == RGN_W'(r))), .addr(seq_addr),
      .wdata(staging[seq_word]), .rdata(ram_rd[r]));
  end

  logic              stg_hit;
  logic [CSR_AW-1:0] stg_off;
  logic [CW-1:0]     stg_idx;
  assign stg_off = csr_addr - CSR_AW'(OFF_STG);
  assign stg_idx = CW'(stg_off >> 2);
  assign stg_hit = (csr_addr >= CSR_AW'(OFF_STG)) &&
                   (csr_addr < CSR_AW'(OFF_STG + 4 * NWORDS)) && (csr_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0; cmd_q <= '0; done_q <= '0; err_q <= 1'b0; bad_q <= 1'b0;
      ok_q <= 1'b0; region_q <= '0; staging <= '0; snode <= '0; spkt <= '0;
    end else begin
      if (csr_we && !seq_busy && (csr_addr == CSR_AW'(OFF_SEL))) sel_q <= csr_wdata;
      if (seq_swe) staging[seq_sidx] <= ram_rd[region_q];
      else if (csr_we && !seq_busy && stg_hit) staging[stg_idx] <= csr_wdata;
      for (int p = 0; p < NPARSERS; p++) begin
        if (csr_we && (csr_addr == CSR_AW'(OFF_SNODE + p * OFF_BANK)))
          snode[p] <= csr_wdata[SNODE_W-1:0];
        if (csr_we && (csr_addr == CSR_AW'(OFF_SPKT + p * OFF_BANK)))
          spkt[p] <= csr_wdata[SPKT_W-1:0];
      end
      if (csr_we && (csr_addr == CSR_AW'(OFF_STAT)) && csr_wdata[31]) err_q <= 1'b0;
      if (cmd_acc) begin
        cmd_q    <= csr_wdata;
        done_q   <= '0;
        region_q <= map_rgn;
        ok_q     <= map_ok;
        bad_q    <= !known_cmd(csr_wdata) || ((is_wr || is_rd) && !map_ok);
      end else if (seq_done) begin
        done_q <= known_cmd(cmd_q) ? cmd_q[5:0] : 6'd0;
        if (bad_q) err_q <= 1'b1;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (csr_addr == CSR_AW'(OFF_SEL))       rd_mux = sel_q;
    else if (csr_addr == CSR_AW'(OFF_CMD))  rd_mux = cmd_q;
    else if (csr_addr == CSR_AW'(OFF_STAT)) rd_mux = {err_q, 25'd0, done_q};
    else if (stg_hit)                       rd_mux = staging[stg_idx];
    for (int p = 0; p < NPARSERS; p++) begin
      if (csr_addr == CSR_AW'(OFF_SNODE + p * OFF_BANK)) rd_mux = 32'(snode[p]);
      if (csr_addr == CSR_AW'(OFF_SPKT + p * OFF_BANK))  rd_mux = 32'(spkt[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0; csr_rvalid <= 1'b0;
    end else begin
      csr_rvalid <= csr_re;
      if (csr_re) csr_rdata <= rd_mux;
    end
  end

  // R5
  done_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(done_q));
  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|done_q) |-> $past(seq_done));
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(csr_we && (csr_addr == CSR_AW'(OFF_STAT)) && csr_wdata[31]));
  // R3
  table_write_chk: assert property (@(posedge clk) disable iff (rst)
    seq_we |-> (ok_q && (cmd_q == CMD_WR)));
  // R9
  staging_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && !seq_swe) |=> $stable(staging));
endmodule

// File: tb/sim_cle_indirect_ctrl.sv
module sim_cle_indirect_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cle_indirect_ctrl u0 (.clk(clk), .rst(rst), .csr_we(csr_we), .csr_re(csr_re),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid));

  function automatic logic [31:0] pat(input int s, input int i);
    return 32'h1000_0000 * s + 32'h0001_0101 * i + 32'h0000_00A5;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); csr_re = 1'b1; csr_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); csr_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input int s);
    for (int i = 0; i < 17; i++) wr(12'(16 + 4 * i), pat(s, i));
  endtask

  task automatic check_stage(input int s, input string tag);
    for (int i = 0; i < 17; i++) rd_exp(12'(16 + 4 * i), pat(s, i), tag);
  endtask

  task automatic cmd(input logic [31:0] c);
    wr(12'h008, c); idle(22);
  endtask

  // monitor: pops expected items as read data returns
  always @(negedge clk) begin
    if (csr_rvalid && !finished) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++; $display("FAIL unexpected read data got %h exp none", csr_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (csr_rdata !== e) begin
          errors++; $display("FAIL %s got %h exp %h", t, csr_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; checks++; errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 1'b0; idle(2);
    // R11 reset values
    rd_exp(12'h004, 32'h0, "R11 selector");
    rd_exp(12'h00C, 32'h0, "R11 status");
    rd_exp(12'h010, 32'h0, "R11 staging0");
    rd_exp(12'h100, 32'h0, "R11 start node");
    // R1 map and readback
    wr(12'h004, 32'hC000_0003);
    rd_exp(12'h004, 32'hC000_0003, "R1 selector readback");
    rd_exp(12'h060, 32'h0, "R1 unmapped offset");
    fill(1);
    rd_exp(12'h050, pat(1, 16), "R1 staging16");
    // R5 exact completion edge
    wr(12'h008, 32'd1);
    idle(16);
    rd_exp(12'h00C, 32'h0, "R5 status before done");
    rd_exp(12'h00C, 32'h1, "R5 status done write");
    // R3 / R4 round trip
    fill(9);
    cmd(32'd2);
    rd_exp(12'h00C, 32'h2, "R4 status read");
    check_stage(1, "R3 R4 entry data");
    // R2 per-parser separation and shared tables
    fill(2); wr(12'h004, 32'h4000_0002); cmd(32'd1);
    fill(3); wr(12'h004, 32'h0000_0002); cmd(32'd1);
    fill(4); wr(12'h004, 32'hE000_0003); cmd(32'd1);
    wr(12'h004, 32'h4000_0002); cmd(32'd2);
    check_stage(2, "R2 parser1 packet table");
    wr(12'h004, 32'hC000_0003); cmd(32'd2);
    check_stage(1, "R2 tree table separate from result");
    // R7 out-of-range index with aliasing low bits
    fill(5); wr(12'h004, 32'hC010_0003); cmd(32'd1);
    rd_exp(12'h00C, 32'h8000_0001, "R7 range error");
    wr(12'h004, 32'hC000_0003); cmd(32'd2);
    rd_exp(12'h00C, 32'h8000_0002, "R7 sticky error");
    check_stage(1, "R7 entry unchanged");
    wr(12'h004, 32'h1000_0000); cmd(32'd2);
    rd_exp(12'h00C, 32'h8000_0002, "R7 unmapped type");
    rd_exp(12'h010, pat(1, 0), "R7 staging unchanged");
    wr(12'h00C, 32'h8000_0000);
    rd_exp(12'h00C, 32'h0000_0002, "R7 error cleared");
    // R6 search commands
    wr(12'h004, 32'hC000_0003); fill(6);
    cmd(32'd8);  rd_exp(12'h00C, 32'h08, "R6 add");
    cmd(32'd16); rd_exp(12'h00C, 32'h10, "R6 delete");
    cmd(32'd32); rd_exp(12'h00C, 32'h20, "R6 search");
    cmd(32'd2);  check_stage(1, "R6 no table change");
    // R8 unknown code
    cmd(32'd3);
    rd_exp(12'h00C, 32'h8000_0000, "R8 unknown code");
    rd_exp(12'h008, 32'd3, "R1 command readback");
    wr(12'h00C, 32'h8000_0000);
    // R9 writes ignored while busy
    wr(12'h008, 32'd1);
    wr(12'h010, 32'hDEAD_BEEF);
    wr(12'h004, 32'hE000_0000);
    wr(12'h008, 32'd2);
    idle(22);
    rd_exp(12'h00C, 32'h1, "R9 second command ignored");
    rd_exp(12'h010, pat(1, 0), "R9 staging write ignored");
    rd_exp(12'h004, 32'hC000_0003, "R9 selector write ignored");
    rd_exp(12'h008, 32'd1, "R9 command register kept");
    // R10 per-parser start registers
    wr(12'h500, 32'hFFFF_FFFF);
    wr(12'h504, 32'hFFFF_FFFF);
    wr(12'h304, 32'h0000_0123);
    rd_exp(12'h500, 32'h0000_3FFF, "R10 start node width");
    rd_exp(12'h504, 32'h0000_01FF, "R10 start packet width");
    rd_exp(12'h304, 32'h0000_0123, "R10 parser1 start packet");
    rd_exp(12'h100, 32'h0, "R10 parser0 independent");
    idle(4);
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL missing read data got %0d pending exp 0", exp_q.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule